// File: doc/BRIEF.md
# Parallel RGB LCD DE-mode timing generator

This block drives a parallel RGB LCD panel that runs in data-enable-only mode, with no separate sync lines. It divides the system clock by a programmable integer to make the panel pixel clock. A pair of nested counters produces the data-enable signal. The horizontal counter keeps DE high for a programmed number of active pixels out of a programmed line length. The vertical counter repeats that line pattern for a programmed number of active lines and then holds DE low for vertical blanking until the frame length is reached.

Pixels arrive as 24-bit words on a ready/valid stream, with blue in bits 7:0, green in bits 15:8 and red in bits 23:16. Each colour is cut to its 6 most significant bits and placed on a 32-pin output group, one byte lane per colour. Per-pin output enables leave the two dropped low bits of each lane undriven, together with the whole fourth lane, so those pins stay free for other uses. Data and DE change on the falling edge of the pixel clock and are steady at its rising edge, which is when the panel samples them. A one-cycle frame marker lets the pixel source realign to the start of each frame. An underrun flag records any active pixel for which the source had no word ready.

Top module: `lcd_de_timing`

## Requirements
- R1: A synchronous active-high reset leaves lcd_clk, lcd_de, frame_start, underrun and pin_out at zero from the next clock edge, and all counters restart at the first pixel of a frame.
- R2: One pixel period lasts N system cycles, where N is cfg_div and values below 2 are treated as 2. Within each period, lcd_clk is low for floor(N/2) cycles and then high for ceil(N/2) cycles.
- R3: Each line lasts cfg_h_total pixel periods. lcd_de is high for the first cfg_h_active of them, or for the whole line when cfg_h_active is at least cfg_h_total.
- R4: Each frame lasts cfg_v_total lines, so one frame is cfg_h_total*cfg_v_total*N system cycles. DE pulses only in the first cfg_v_active lines and stays low for the rest of the frame.
- R5: The configuration inputs are sampled only at the first pixel period of a frame. A change made during a frame takes effect from the next frame.
- R6: frame_start is a single-cycle pulse in the first system cycle of each frame's first pixel period, while lcd_clk is low.
- R7: pix_ready is high for exactly one system cycle, the last cycle of the period before each active pixel period. One word is consumed per active pixel, so cfg_h_active*cfg_v_active words are taken per frame.
- R8: During an active period, pin_out[7:2] carries pixel bits 7:2 (blue), pin_out[15:10] carries bits 15:10 (green) and pin_out[23:18] carries bits 23:18 (red).
- R9: pin_oe is 0x00FCFCFC, and pin_out is zero on every pin whose enable is low.
- R10: pin_out and lcd_de change only while lcd_clk is low, and they are stable across each rising edge of lcd_clk.
- R11: If pix_valid is low when a word is requested, that pixel is output as zero and underrun goes high. underrun stays high until reset, and DE timing is unaffected.
- R12: pin_out is zero whenever lcd_de is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | DIV_W | System cycles per pixel period (minimum 2) |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_total | input | HW | Total pixel periods per line |
| cfg_v_active | input | VW | Active lines per frame |
| cfg_v_total | input | VW | Total lines per frame |
| pix_data | input | 24 | Pixel word: red 23:16, green 15:8, blue 7:0 |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Pixel word consumed this cycle if valid |
| lcd_clk | output | 1 | Panel pixel clock |
| lcd_de | output | 1 | Panel data enable |
| pin_out | output | 32 | Output pin values, four byte lanes |
| pin_oe | output | 32 | Per-pin output enables |
| frame_start | output | 1 | One-cycle marker at the start of each frame |
| underrun | output | 1 | Sticky flag: an active pixel found no valid word |

## Verification
The assertions assume that cfg_h_total and cfg_v_total are non-zero, so that every line and every frame ends. The single-cycle pix_ready property depends on the divider clamp, which keeps each pixel period at least two cycles long. The bench always uses non-zero totals. It changes configuration and pix_valid only at falling system-clock edges, holds pix_data steady until a word has been consumed, and avoids settings in which DE would never drop across a frame boundary.

// File: rtl/lcd_de_timing.sv
module lcd_de_timing #(
  parameter int DIV_W = 8,
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int KEEP  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [HW-1:0]    cfg_h_active,
  input  logic [HW-1:0]    cfg_h_total,
  input  logic [VW-1:0]    cfg_v_active,
  input  logic [VW-1:0]    cfg_v_total,
  input  logic [23:0]      pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             lcd_clk,
  output logic             lcd_de,
  output logic [31:0]      pin_out,
  output logic [31:0]      pin_oe,
  output logic             frame_start,
  output logic             underrun
);
  localparam int LANE    = 8;
  localparam int COLOURS = 3;

  function automatic logic [31:0] lane_mask();
    logic [31:0] m = '0;
    for (int l = 0; l < COLOURS; l++)
      for (int b = LANE - KEEP; b < LANE; b++)
        m[l*LANE + b] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] OE_MASK = lane_mask();

  logic [DIV_W-1:0] dcnt, div_r;
  logic [HW-1:0]    hcnt, ha_r, ht_r;
  logic [VW-1:0]    vcnt, va_r, vt_r;
  logic [23:0]      pix_r;

  wire bnd = (dcnt == '0);
  wire fs  = (hcnt == '0) && (vcnt == '0);

  wire [DIV_W-1:0] div_cfg = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
  wire [DIV_W-1:0] div_use = fs ? div_cfg      : div_r;
  wire [HW-1:0]    ha_use  = fs ? cfg_h_active : ha_r;
  wire [HW-1:0]    ht_use  = fs ? cfg_h_total  : ht_r;
  wire [VW-1:0]    va_use  = fs ? cfg_v_active : va_r;
  wire [VW-1:0]    vt_use  = fs ? cfg_v_total  : vt_r;

  wire de_next   = (hcnt < ha_use) && (vcnt < va_use);
  wire line_end  = (hcnt == ht_use - HW'(1));
  wire frame_end = line_end && (vcnt == vt_use - VW'(1));
  wire [DIV_W-1:0] half = div_r - (div_r >> 1);

  assign pix_ready = bnd && de_next && !rst;
  assign pin_oe    = OE_MASK;
  assign pin_out   = {8'h00, pix_r} & OE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt        <= '0;
      div_r       <= '0;
      hcnt        <= '0;
      vcnt        <= '0;
      ha_r        <= '0;
      ht_r        <= '0;
      va_r        <= '0;
      vt_r        <= '0;
      pix_r       <= '0;
      lcd_clk     <= 1'b0;
      lcd_de      <= 1'b0;
      frame_start <= 1'b0;
      underrun    <= 1'b0;
    end else if (bnd) begin
      if (fs) begin
        div_r <= div_cfg;
        ha_r  <= cfg_h_active;
        ht_r  <= cfg_h_total;
        va_r  <= cfg_v_active;
        vt_r  <= cfg_v_total;
      end
      dcnt        <= div_use - DIV_W'(1);
      hcnt        <= line_end ? '0 : hcnt + HW'(1);
      vcnt        <= frame_end ? '0 : (line_end ? vcnt + VW'(1) : vcnt);
      lcd_clk     <= 1'b0;
      lcd_de      <= de_next;
      pix_r       <= (de_next && pix_valid) ? pix_data : '0;
      frame_start <= fs;
      if (de_next && !pix_valid) underrun <= 1'b1;
    end else begin
      dcnt        <= dcnt - DIV_W'(1);
      lcd_clk     <= (dcnt <= half);
      frame_start <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_de_timing_chk.sv
module lcd_de_timing_chk (
  input logic        clk,
  input logic        rst,
  input logic        lcd_clk,
  input logic        lcd_de,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic        pix_ready,
  input logic        frame_start,
  input logic        underrun
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!lcd_de && !lcd_clk && !frame_start && !underrun && pin_out == 32'h0));

  assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> !pix_ready);

  assert_frame_mark_low_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !lcd_clk);

  assert_frame_mark_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  assert_undriven_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == 32'h0);

  assert_de_moves_low_R10: assert property (@(posedge clk) disable iff (rst)
    $changed(lcd_de) |-> !lcd_clk);

  assert_stable_at_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_clk) |-> ($stable(pin_out) && $stable(lcd_de)));

  assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  assert_blank_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !lcd_de |-> (pin_out == 32'h0));
endmodule

bind lcd_de_timing lcd_de_timing_chk u_chk (.*);

// File: tb/sim_lcd_de_timing.sv
module sim_lcd_de_timing;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd4;
  logic [11:0] cfg_h_active = 12'd5, cfg_h_total = 12'd8;
  logic [11:0] cfg_v_active = 12'd3, cfg_v_total = 12'd5;
  logic [23:0] pix_data = 24'h13579B;
  logic        pix_valid = 1'b1;
  logic        pix_ready, lcd_clk, lcd_de, frame_start, underrun;
  logic [31:0] pin_out, pin_oe;

  localparam logic [31:0] OE_EXP = 32'h00FCFCFC;
  // div, h_active, h_total, v_active, v_total, expected frame length
  localparam int VEC [5][6] = '{
    '{4, 5, 8, 3, 5, 160},
    '{2, 3, 4, 2, 3, 24},
    '{3, 6, 6, 2, 4, 72},
    '{1, 2, 5, 4, 4, 40},
    '{5, 4, 7, 0, 3, 105}
  };

  int checks = 0, fails = 0;

  lcd_de_timing u0 (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and pixel source
  int req = 0, ack = 0;
  bit started = 0;
  int m_len, m_de, m_run, m_max, m_pop, m_clkhi, m_data, m_blank, m_phase, m_fs;
  logic [31:0] last_exp = '0, prev_out = '0;
  logic prev_de = 0, prev_fs = 0, pend = 0;

  always @(negedge clk) begin
    if (req != ack) begin
      if (started && frame_start) begin
        started = 0;
        ack = req;
      end else begin
        if (frame_start && !started) begin
          started = 1;
          m_len = 0; m_de = 0; m_run = 0; m_max = 0; m_pop = 0;
          m_clkhi = 0; m_data = 0; m_blank = 0; m_phase = 0; m_fs = 0;
        end
        if (started) begin
          m_len++;
          if (lcd_de) begin m_run++; m_de++; end else m_run = 0;
          if (m_run > m_max) m_max = m_run;
          if (lcd_clk) m_clkhi++;
          if (pix_ready && pix_valid) m_pop++;
          if (lcd_de && lcd_clk && pin_out != last_exp) m_data++;
          if (!lcd_de && pin_out != 0) m_blank++;
          if (lcd_clk && (pin_out != prev_out || lcd_de != prev_de)) m_phase++;
          if (frame_start && (lcd_clk || prev_fs)) m_fs++;
        end
      end
    end
    prev_out = pin_out;
    prev_de  = lcd_de;
    prev_fs  = frame_start;
    if (pend) begin
      pix_data = pix_data + 24'h3A5F1B;
      pend = 0;
    end
    if (pix_ready) begin
      last_exp = pix_valid ? ({8'h00, pix_data} & OE_EXP) : 32'h0;
      if (pix_valid) pend = 1;
    end
  end

  task automatic measure_frame();
    req++;
    wait (ack == req);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input int d, input int ha, input int ht, input int va, input int vt);
    cfg_div = 8'(d); cfg_h_active = 12'(ha); cfg_h_total = 12'(ht);
    cfg_v_active = 12'(va); cfg_v_total = 12'(vt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!lcd_de && !lcd_clk && !frame_start && !underrun && pin_out == 0,
          "R1 reset outputs", int'(pin_out), 0);
    // R9: enables
    check(pin_oe == OE_EXP, "R9 output enables", int'(pin_oe), int'(OE_EXP));

    for (int i = 0; i < 5; i++) begin
      int n, ha_e, va_e, exp_run;
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      pix_valid = 1'b1;
      do_reset();
      measure_frame();
      n    = (VEC[i][0] < 2) ? 2 : VEC[i][0];
      ha_e = (VEC[i][1] < VEC[i][2]) ? VEC[i][1] : VEC[i][2];
      va_e = (VEC[i][3] < VEC[i][4]) ? VEC[i][3] : VEC[i][4];
      exp_run = (va_e == 0) ? 0 :
                ((VEC[i][1] >= VEC[i][2]) ? VEC[i][2] * va_e * n : VEC[i][1] * n);
      check(m_len == VEC[i][5], "R4 frame length", m_len, VEC[i][5]);
      check(m_de == ha_e * va_e * n, "R3 DE cycles per frame", m_de, ha_e * va_e * n);
      check(m_max == exp_run, "R3 longest DE run", m_max, exp_run);
      check(m_clkhi == ((n + 1) / 2) * VEC[i][2] * VEC[i][4], "R2 clock high cycles",
            m_clkhi, ((n + 1) / 2) * VEC[i][2] * VEC[i][4]);
      check(m_pop == ha_e * va_e, "R7 words consumed", m_pop, ha_e * va_e);
      check(m_data == 0, "R8 truncated data", m_data, 0);
      check(m_blank == 0, "R12 blank data zero", m_blank, 0);
      check(m_phase == 0, "R10 changes while clock high", m_phase, 0);
      check(m_fs == 0, "R6 frame marker shape", m_fs, 0);
      check(!underrun, "R11 no underrun with valid source", int'(underrun), 0);
    end

    // R5: mid-frame configuration change
    set_cfg(2, 3, 4, 2, 3);
    do_reset();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
    set_cfg(4, 5, 8, 3, 5);
    begin
      int len = 0;
      do begin len++; @(negedge clk); end while (!frame_start);
      check(len == 24, "R5 frame keeps old config", len, 24);
    end
    measure_frame();
    check(m_len == 160, "R5 new config next frame", m_len, 160);
    check(m_pop == 15, "R5 new active area", m_pop, 15);

    // R11: underrun
    set_cfg(2, 3, 4, 2, 3);
    pix_valid = 1'b0;
    do_reset();
    measure_frame();
    check(underrun, "R11 underrun raised", int'(underrun), 1);
    check(m_data == 0, "R11 zero data on underrun", m_data, 0);
    check(m_len == 24 && m_de == 12, "R11 timing not stalled", m_len, 24);
    @(negedge clk) pix_valid = 1'b1;
    measure_frame();
    check(underrun, "R11 underrun sticky", int'(underrun), 1);
    check(m_data == 0, "R8 data after recovery", m_data, 0);

    // R1: reset clears sticky flag
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!underrun && !lcd_de && !lcd_clk && pin_out == 0, "R1 reset clears",
          int'(underrun), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule